// File: doc/BRIEF.md
# External Static Memory Bus Adapter

The adapter turns internal read and write requests into bus cycles on an external static-memory bus shared by eight chip-select regions. The internal byte address holds the region index in bits [28:26] and the 26-bit offset inside that region's 64 Mbyte window in bits [25:0]. Each region has its own data width (8, 16 or 32 bits) and its own byte-write style. Both are supplied as static configuration inputs.

A request is held on the internal side until a one-cycle ready pulse. An access wider than the region's device is split into consecutive bus cycles, lowest byte address first. On a read, the bytes are placed in their internal lanes before ready is raised. All bus cycles use fixed timing:
- one address cycle before the first beat;
- per beat, one setup cycle, two strobe cycles and one hold cycle.

A device smaller than its window simply ignores the upper offset bits, so it repeats through the window. The adapter always drives the full offset.

Top module: `stmem_bus_adapter`

## Requirements
- R1: Address bits [28:26] select the region. Only that region's active-low chip select is low, and only during its bus cycles (setup through hold). All chip selects are high when idle and during the address cycle.
- R2: `mem_addr` carries offset bits [25:0] of the current beat. The bits below the device width are forced to zero: none for 8-bit, bit 0 for 16-bit, bits [1:0] for 32-bit.
- R3: A request starts with one address cycle with all chip selects high. Each beat then has one setup cycle with its chip select low, two cycles with the strobe low, and one hold cycle with the strobe high and the chip select still low. No chip select or strobe changes at a clock edge where `mem_addr` changes.
- R4: When the access size exceeds the device width, the access takes size/width beats at increasing byte addresses. The chip select stays low between beats.
- R5: On a write, device lane L carries the request byte whose address modulo 4 selects the internal lane. Lanes not covered in the beat are driven to zero, including the unused upper lanes of 8- and 16-bit devices. `mem_doe` is high from setup through hold of write beats.
- R6: `req_ready` is high for exactly the final hold cycle, and in that cycle `req_rdata` holds the read bytes in their internal lanes (byte at address A in lane A mod 4). Internal lanes outside the access read as zero.
- R7: In byte-write style (`cfg_bsel` bit 0) on a 16- or 32-bit device, a write pulls low `mem_we_n` for exactly the covered lanes during the strobe cycles and keeps `mem_wr_n` high. A read pulls low only `mem_rd_n` and no `mem_we_n` line.
- R8: In byte-select style (`cfg_bsel` bit 1) on a 16- or 32-bit device, `mem_bs_n` is low for the covered lanes from setup through hold on both reads and writes. Writes use the common `mem_wr_n`.
- R9: Each region has two bits in `cfg_width` at [2k+1:2k]: 0 = 8-bit, 1 = 16-bit, 2 or 3 = 32-bit. An 8-bit device writes with `mem_wr_n` and never pulls low `mem_we_n` or `mem_bs_n`.
- R10: `req_size` encodes 0 = byte, 1 = halfword, 2 or 3 = word. Address bits below the access size are ignored, so the access is aligned down to its size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present, held until ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access size code |
| req_addr | input | 29 | Region index and offset |
| req_wdata | input | 32 | Write data in internal lanes |
| req_ready | output | 1 | Request complete, one cycle |
| req_rdata | output | 32 | Assembled read data |
| cfg_width | input | 16 | Per-region width codes |
| cfg_bsel | input | 8 | Per-region style, 1 = byte-select |
| mem_cs_n | output | 8 | Active-low chip selects |
| mem_addr | output | 26 | External address lines |
| mem_rd_n | output | 1 | Active-low read strobe |
| mem_wr_n | output | 1 | Active-low common write strobe |
| mem_we_n | output | 4 | Active-low per-lane write strobes |
| mem_bs_n | output | 4 | Active-low byte-select lines |
| mem_dout | output | 32 | Write data to the bus |
| mem_doe | output | 1 | Write data drive enable |
| mem_din | input | 32 | Read data from the bus |

## Verification
The bound checker watches the bus on every cycle. It checks that at most one chip select is low and that strobes only occur inside a chip select. It checks that strobe pulses are two cycles long, that reads and writes are exclusive, and that strobes and chip selects hold still whenever the address moves. It also checks that ready falls in a hold cycle and is followed by release of the chip select, and that an 8-bit region drives zero on its upper lanes. The lane mapping cannot be seen from cycle-local rules: beat order, split addresses, per-lane strobe and select masks, write data routing and read-data assembly. The directed scenarios check these cycle by cycle against values computed from the request.

// File: rtl/stmem_bus_adapter.sv
module stmem_bus_adapter #(
  parameter int NCS   = 8,
  parameter int OFF_W = 26
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  input  logic                          req_write,
  input  logic [1:0]                    req_size,
  input  logic [OFF_W+$clog2(NCS)-1:0]  req_addr,
  input  logic [31:0]                   req_wdata,
  output logic                          req_ready,
  output logic [31:0]                   req_rdata,
  input  logic [2*NCS-1:0]              cfg_width,
  input  logic [NCS-1:0]                cfg_bsel,
  output logic [NCS-1:0]                mem_cs_n,
  output logic [OFF_W-1:0]              mem_addr,
  output logic                          mem_rd_n,
  output logic                          mem_wr_n,
  output logic [3:0]                    mem_we_n,
  output logic [3:0]                    mem_bs_n,
  output logic [31:0]                   mem_dout,
  output logic                          mem_doe,
  input  logic [31:0]                   mem_din
);
  localparam int CSW = $clog2(NCS);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_SETUP, S_STB1, S_STB2, S_HOLD} st_t;

  st_t              st;
  logic [CSW-1:0]   cs_q;
  logic             wr_q, bs_q;
  logic [1:0]       wl_q, sz_q, beat_q;
  logic [31:0]      wd_q, rd_q;
  logic [OFF_W-1:0] ba_q;

  logic [CSW-1:0] req_cs;
  logic [1:0]     req_wc, req_wl, req_sl;
  logic [1:0]     bl, wm, nm, last_beat;
  logic [3:0]     cov;
  logic [1:0]     xl [4];
  logic           active, strobe, wide, last;

  assign req_cs = req_addr[OFF_W +: CSW];
  assign req_wc = cfg_width[{req_cs, 1'b0} +: 2];
  assign req_wl = (req_wc == 2'd3) ? 2'd2 : req_wc;
  assign req_sl = (req_size == 2'd3) ? 2'd2 : req_size;

  assign bl = (sz_q > wl_q) ? wl_q : sz_q;
  assign wm = (wl_q == 2'd0) ? 2'd0 : (wl_q == 2'd1) ? 2'd1 : 2'd3;
  assign nm = (bl == 2'd0) ? 2'd0 : (bl == 2'd1) ? 2'd1 : 2'd3;

  always_comb begin
    last_beat = 2'd0;
    if (sz_q > wl_q) last_beat = (sz_q - wl_q == 2'd1) ? 2'd1 : 2'd3;
  end

  assign last   = (beat_q == last_beat);
  assign active = (st == S_SETUP) || (st == S_STB1) || (st == S_STB2) || (st == S_HOLD);
  assign strobe = (st == S_STB1) || (st == S_STB2);
  assign wide   = (wl_q != 2'd0);

  always_comb begin
    for (int l = 0; l < 4; l++) begin
      xl[l]  = (ba_q[1:0] & ~wm) | 2'(l);
      cov[l] = (2'(l) <= wm) && ((xl[l] & ~nm) == (ba_q[1:0] & ~nm));
    end
  end

  always_comb begin
    mem_dout = '0;
    for (int l = 0; l < 4; l++)
      if (wr_q && active && cov[l]) mem_dout[8*l +: 8] = wd_q[8*xl[l] +: 8];
  end

  assign mem_cs_n  = active ? ~(NCS'(1) << cs_q) : '1;
  assign mem_addr  = ba_q & ~OFF_W'(wm);
  assign mem_rd_n  = !(strobe && !wr_q);
  assign mem_wr_n  = !(strobe && wr_q && (!wide || bs_q));
  assign mem_we_n  = ~({4{strobe && wr_q && wide && !bs_q}} & cov);
  assign mem_bs_n  = ~({4{active && wide && bs_q}} & cov);
  assign mem_doe   = active && wr_q;
  assign req_ready = (st == S_HOLD) && last;
  assign req_rdata = rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cs_q   <= '0;
      wr_q   <= 1'b0;
      bs_q   <= 1'b0;
      wl_q   <= 2'd0;
      sz_q   <= 2'd0;
      beat_q <= 2'd0;
      wd_q   <= '0;
      rd_q   <= '0;
      ba_q   <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          cs_q   <= req_cs;
          wr_q   <= req_write;
          bs_q   <= cfg_bsel[req_cs];
          wl_q   <= req_wl;
          sz_q   <= req_sl;
          wd_q   <= req_wdata;
          rd_q   <= '0;
          beat_q <= 2'd0;
          ba_q   <= req_addr[OFF_W-1:0] &
                    ~OFF_W'((req_sl == 2'd0) ? 2'd0 : (req_sl == 2'd1) ? 2'd1 : 2'd3);
          st     <= S_ADDR;
        end
        S_ADDR:  st <= S_SETUP;
        S_SETUP: st <= S_STB1;
        S_STB1:  st <= S_STB2;
        S_STB2: begin
          if (!wr_q)
            for (int l = 0; l < 4; l++)
              if (cov[l]) rd_q[8*xl[l] +: 8] <= mem_din[8*l +: 8];
          st <= S_HOLD;
        end
        S_HOLD: begin
          if (last) st <= S_IDLE;
          else begin
            ba_q   <= ba_q + OFF_W'(nm) + OFF_W'(1);
            beat_q <= beat_q + 2'd1;
            st     <= S_SETUP;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/stmem_bus_adapter_chk.sv
module stmem_bus_adapter_chk #(
  parameter int NCS   = 8,
  parameter int OFF_W = 26
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_ready,
  input logic [2*NCS-1:0]   cfg_width,
  input logic [NCS-1:0]     mem_cs_n,
  input logic [OFF_W-1:0]   mem_addr,
  input logic               mem_rd_n,
  input logic               mem_wr_n,
  input logic [3:0]         mem_we_n,
  input logic [31:0]        mem_dout,
  input logic               mem_doe
);
  p_cs_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~mem_cs_n));

  p_strobe_in_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_rd_n || !mem_wr_n || (mem_we_n != 4'hF)) |-> (mem_cs_n != '1));

  p_addr_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mem_addr) |-> ($stable(mem_cs_n) && $stable(mem_rd_n) &&
                            $stable(mem_wr_n) && $stable(mem_we_n)));

  p_rd_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_rd_n) |=> !mem_rd_n ##1 mem_rd_n);

  p_wr_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_wr_n) |=> !mem_wr_n ##1 mem_wr_n);

  p_rw_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_rd_n |-> (mem_wr_n && (mem_we_n == 4'hF)));

  p_wstyle_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_wr_n |-> (mem_we_n == 4'hF));

  p_ready_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> ((mem_cs_n != '1) && mem_rd_n && mem_wr_n && (mem_we_n == 4'hF)));

  p_ready_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> (!req_ready && (mem_cs_n == '1)));

  for (genvar g = 0; g < NCS; g++) begin : g_narrow
    p_narrow_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_cs_n[g] && mem_doe && (cfg_width[2*g +: 2] == 2'd0)) |-> (mem_dout[31:8] == 24'd0));
  end
endmodule

bind stmem_bus_adapter stmem_bus_adapter_chk #(.NCS(NCS), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .cfg_width(cfg_width),
  .mem_cs_n(mem_cs_n), .mem_addr(mem_addr), .mem_rd_n(mem_rd_n),
  .mem_wr_n(mem_wr_n), .mem_we_n(mem_we_n), .mem_dout(mem_dout), .mem_doe(mem_doe)
);

// File: tb/stmem_bus_adapter_tb.sv
module stmem_bus_adapter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [28:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready;
  logic [31:0] req_rdata;
  logic [15:0] cfg_width = {2'd3, 2'd2, 2'd0, 2'd2, 2'd1, 2'd0, 2'd1, 2'd2};
  logic [7:0]  cfg_bsel  = 8'b1100_0010;
  logic [7:0]  mem_cs_n;
  logic [25:0] mem_addr;
  logic        mem_rd_n, mem_wr_n, mem_doe;
  logic [3:0]  mem_we_n, mem_bs_n;
  logic [31:0] mem_dout, mem_din;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  function automatic logic [31:0] din_of(input logic [25:0] a);
    logic [31:0] d;
    for (int l = 0; l < 4; l++) d[8*l +: 8] = a[9:2] + 8'(l * 37) + 8'h11;
    return d;
  endfunction

  assign mem_din = din_of(mem_addr);

  stmem_bus_adapter u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .req_rdata(req_rdata), .cfg_width(cfg_width),
    .cfg_bsel(cfg_bsel), .mem_cs_n(mem_cs_n), .mem_addr(mem_addr),
    .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .mem_we_n(mem_we_n),
    .mem_bs_n(mem_bs_n), .mem_dout(mem_dout), .mem_doe(mem_doe), .mem_din(mem_din)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic idle_check(input string tag);
    check(mem_cs_n == 8'hFF, tag, "idle cs_n", 32'(mem_cs_n), 32'hFF);
    check(!req_ready, tag, "idle ready", 32'(req_ready), 0);
    check(mem_rd_n && mem_wr_n && mem_we_n == 4'hF, tag, "idle strobes",
          {mem_rd_n, mem_wr_n, mem_we_n}, 32'h3F);
  endtask

  // Drives one request and checks every bus cycle against values derived from R1-style rules.
  task automatic access(input int cs, input logic [25:0] off, input int size,
                        input bit wr, input logic [31:0] wdata, input string tag);
    int wc = int'(cfg_width[2*cs +: 2]);
    int wl = (wc == 3) ? 2 : wc;
    int sl = (size == 3) ? 2 : size;
    int W = 1 << wl, S = 1 << sl;
    int n = (S < W) ? S : W;
    int nb = S / n;
    bit bs = cfg_bsel[cs];
    logic [25:0] base = off & ~26'(S - 1);
    logic [31:0] rexp = '0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_size = 2'(size);
    req_addr = {3'(cs), off}; req_wdata = wdata;
    @(negedge clk);
    check(mem_cs_n == 8'hFF, "R3", "address cycle cs_n", 32'(mem_cs_n), 32'hFF);
    check(mem_addr == (base & ~26'(W - 1)), "R2", "address cycle addr",
          32'(mem_addr), 32'(base & ~26'(W - 1)));
    for (int b = 0; b < nb; b++) begin
      logic [25:0] ba = base + 26'(b * n);
      logic [25:0] ea = ba & ~26'(W - 1);
      logic [3:0]  mask = '0;
      logic [31:0] dexp = '0;
      logic [3:0]  bsx, wex;
      logic        wrx, rdx;
      for (int k = 0; k < n; k++) begin
        int x = int'(ba) + k;
        int lane = x % W;
        mask[lane] = 1'b1;
        dexp[8*lane +: 8] = wdata[8*(x % 4) +: 8];
        rexp[8*(x % 4) +: 8] = din_of(ea)[8*lane +: 8];
      end
      bsx = (W > 1 && bs) ? ~mask : 4'hF;
      rdx = wr;
      wrx = !(wr && (W == 1 || bs));
      wex = (wr && W > 1 && !bs) ? ~mask : 4'hF;
      for (int c = 0; c < 4; c++) begin
        bit stb = (c == 1 || c == 2);
        @(negedge clk);
        check(mem_cs_n == ~(8'd1 << cs), "R1", "chip select", 32'(mem_cs_n), 32'(~(8'd1 << cs)));
        check(mem_addr == ea, (nb > 1) ? "R4" : "R2", "beat addr", 32'(mem_addr), 32'(ea));
        check(mem_bs_n == bsx, (W > 1) ? "R8" : "R9", "byte select", 32'(mem_bs_n), 32'(bsx));
        check(mem_rd_n == (stb ? rdx : 1'b1), "R3", "read strobe", 32'(mem_rd_n), 32'(stb ? rdx : 1'b1));
        check(mem_wr_n == (stb ? wrx : 1'b1), (W == 1) ? "R9" : "R8", "write strobe",
              32'(mem_wr_n), 32'(stb ? wrx : 1'b1));
        check(mem_we_n == (stb ? wex : 4'hF), "R7", "lane strobes",
              32'(mem_we_n), 32'(stb ? wex : 4'hF));
        if (wr) begin
          check(mem_doe, "R5", "drive enable", 32'(mem_doe), 1);
          check(mem_dout == dexp, "R5", "write lanes", mem_dout, dexp);
        end
        if (c == 3) begin
          check(req_ready == (b == nb - 1), "R6", "ready", 32'(req_ready), 32'(b == nb - 1));
          if (b == nb - 1 && !wr) check(req_rdata == rexp, "R6", "read data", req_rdata, rexp);
        end else begin
          check(!req_ready, "R6", "early ready", 32'(req_ready), 0);
        end
      end
    end
    req_valid = 1'b0;
    @(negedge clk);
    idle_check(tag);
  endtask

  task automatic t_reset();
    idle_check("R1");
    check(req_rdata == 0, "R6", "reset rdata", req_rdata, 0);
  endtask
  task automatic t_word32_bw();
    access(0, 26'h0001230, 2, 1'b1, 32'hA1B2C3D4, "R7");
    access(0, 26'h0001230, 2, 1'b0, 32'h0, "R7");
  endtask
  task automatic t_half16_bs();
    access(1, 26'h0000042, 1, 1'b1, 32'h1122_3344, "R8");
    access(1, 26'h0000042, 1, 1'b0, 32'h0, "R8");
    access(1, 26'h0000045, 0, 1'b1, 32'h5566_7788, "R8");
  endtask
  task automatic t_word8();
    access(2, 26'h0000104, 2, 1'b1, 32'hDEAD_BEEF, "R4");
    access(2, 26'h0000104, 2, 1'b0, 32'h0, "R4");
    access(2, 26'h0000106, 1, 1'b0, 32'h0, "R9");
  endtask
  task automatic t_byte32();
    access(0, 26'h0000203, 0, 1'b1, 32'h99AA_BBCC, "R7");
    access(0, 26'h0000203, 0, 1'b0, 32'h0, "R6");
  endtask
  task automatic t_word16_bw();
    access(3, 26'h0000308, 2, 1'b1, 32'h0BAD_F00D, "R4");
    access(3, 26'h000030A, 1, 1'b0, 32'h0, "R7");
  endtask
  task automatic t_high_window();
    access(7, 26'h3FFFFFC, 3, 1'b0, 32'h0, "R1");
    access(5, 26'h3FFFFFF, 0, 1'b1, 32'h0000_00E7, "R2");
  endtask
  task automatic t_unaligned();
    access(4, 26'h0000413, 2, 1'b0, 32'h0, "R10");
    access(6, 26'h0000517, 1, 1'b1, 32'hCAFE_1234, "R10");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_word32_bw();
    t_half16_bs();
    t_word8();
    t_byte32();
    t_word16_bw();
    t_high_window();
    t_unaligned();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog run did not complete actual=%h expected=%h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule